// File: doc/BRIEF.md
# Closed-Caption Line Data Serializer

This block produces the digital data level for one closed-caption line per video field. At the start of a chosen line it emits a clock run-in, a three-bit start pattern and then sixteen data bits. On odd fields the sixteen bits come from a pair of caption bytes. On even fields they come from a separate pair of extended-data bytes. Each byte is sent least significant bit first, and its top bit serves as the parity bit.

A downstream composite encoder takes `data_bit` and `data_valid` on every pixel clock and applies its own shaping. The output is a waveform tied to video timing, so it has no ready input and no back-pressure. The window runs at its own pace once it has started, and the consumer must take every sample while `data_valid` is high.

The bit period is a whole number of pixel clocks and is programmable. The line number that triggers a window is programmable separately for each field. Bytes and settings are captured when the window starts, so any change made while a window is running first appears in the next field.

Top module: `cc_line_serializer`

## Requirements
- R1: Outside a window and after reset, `data_valid` is 0 and `data_bit` is 0 (blanking level).
- R2: A window starts only when `line_start` is sampled high while `line_num` equals `odd_line` (with `field_odd`=1) or `even_line` (with `field_odd`=0). Any other pulse produces no output.
- R3: Slots 0 to 6 form the run-in. Each slot lasts P clocks: `data_bit` is 1 for the first floor(P/2) clocks and 0 for the rest.
- R4: Slots 7, 8 and 9 carry the fixed start pattern 0, 0, 1.
- R5: Slots 10 to 17 carry byte 0 with bit 0 first. Slots 18 to 25 carry byte 1 with bit 0 first.
- R6: A window on an odd field sends `odd_byte0`/`odd_byte1`. A window on an even field sends `even_byte0`/`even_byte1`.
- R7: With `parity_gen`=1, bit 7 of each sent byte is replaced by the odd-parity bit of bits 6..0, so all eight bits together hold an odd number of ones. With `parity_gen`=0, bit 7 is sent unchanged.
- R8: The bit period P equals `bit_div` when `bit_div` is 2 or more. Otherwise P is the parameter default of 32.
- R9: Bytes, `parity_gen` and `bit_div` are captured when the window starts. Changes made during a window, and `line_start` pulses that arrive during a window, have no effect on that window.
- R10: `data_valid` rises in the cycle after the starting `line_start` is sampled. It stays high for exactly 26·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each video line |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| line_num | input | LINE_W | Current line number |
| odd_line | input | LINE_W | Caption line number for odd fields |
| even_line | input | LINE_W | Caption line number for even fields |
| bit_div | input | DIV_W | Pixel clocks per bit (values below 2 select the default) |
| parity_gen | input | 1 | 1 = compute bit 7 as odd parity |
| odd_byte0 | input | 8 | First caption byte, odd field |
| odd_byte1 | input | 8 | Second caption byte, odd field |
| even_byte0 | input | 8 | First extended-data byte, even field |
| even_byte1 | input | 8 | Second extended-data byte, even field |
| data_bit | output | 1 | Serial data level |
| data_valid | output | 1 | High during the caption window |

## Verification
The bench uses the defaults LINE_W=10, DIV_W=8 and DEF_DIV=32. It drives `bit_div` with 0 and 1 to reach the default period, and also with 2, 3 and small random values. The odd periods exercise the floor in the run-in high phase, and the short periods allow many full windows with random bytes in both fields. Directed windows change the bytes, the parity mode and the period partway through a window and also re-pulse `line_start` there. Others pulse `line_start` on a non-matching line or with the wrong field.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NUM_RUNIN   = 7;
  localparam int FRAME_SLOT0 = 7;
  localparam int DATA_SLOT0  = 10;
  localparam int NUM_SLOTS   = 26;
  localparam int SLOT_W      = 5;

  function automatic logic [7:0] fix_parity(input logic [7:0] b, input logic gen);
    return gen ? {~^b[6:0], b[6:0]} : b;
  endfunction
endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] per,
  output logic             bit_end,
  output logic             first_half
);
  logic [DIV_W-1:0] cnt;

  assign bit_end    = run && (cnt == per - 1'b1);
  assign first_half = cnt < (per >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (start || !run || bit_end) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assert_cnt_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < per);
endmodule

// File: rtl/cc_frame_seq.sv
module cc_frame_seq
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_end,
  output logic              active,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (start) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (active && bit_end) begin
      if (slot == SLOT_W'(NUM_SLOTS - 1)) active <= 1'b0;
      else                                slot   <= slot + 1'b1;
    end
  end

  assert_slot_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> slot < SLOT_W'(NUM_SLOTS));
  assert_end_on_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(slot) == SLOT_W'(NUM_SLOTS - 1));
endmodule

// File: rtl/cc_byte_latch.sv
module cc_byte_latch
  import cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        hold,
  input  logic        sel_odd,
  input  logic        parity_gen,
  input  logic [7:0]  odd_b0,
  input  logic [7:0]  odd_b1,
  input  logic [7:0]  even_b0,
  input  logic [7:0]  even_b1,
  output logic [15:0] word
);
  logic [7:0] raw [2];
  logic [7:0] fixed [2];

  assign raw[0] = sel_odd ? odd_b0 : even_b0;
  assign raw[1] = sel_odd ? odd_b1 : even_b1;

  for (genvar i = 0; i < 2; i++) begin : g_byte
    assign fixed[i] = fix_parity(raw[i], parity_gen);
    always_ff @(posedge clk) begin
      if (!rst_n)       word[8*i +: 8] <= '0;
      else if (capture) word[8*i +: 8] <= fixed[i];
    end
  end

  assert_word_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold) && !capture) |-> $stable(word));
endmodule

// File: rtl/cc_line_serializer.sv
module cc_line_serializer
  import cc_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] odd_line,
  input  logic [LINE_W-1:0] even_line,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              parity_gen,
  input  logic [7:0]        odd_byte0,
  input  logic [7:0]        odd_byte1,
  input  logic [7:0]        even_byte0,
  input  logic [7:0]        even_byte1,
  output logic              data_bit,
  output logic              data_valid
);
  localparam logic [DIV_W-1:0] DEF_PER = DIV_W'(DEF_DIV);

  logic              active, start, line_match, bit_end, first_half;
  logic [SLOT_W-1:0] slot;
  logic [DIV_W-1:0]  per_eff, per_q;
  logic [15:0]       word;
  logic [3:0]        didx;

  assign line_match = field_odd ? (line_num == odd_line) : (line_num == even_line);
  assign start      = line_start && line_match && !active;
  assign per_eff    = (bit_div < DIV_W'(2)) ? DEF_PER : bit_div;

  always_ff @(posedge clk) begin
    if (!rst_n)     per_q <= DEF_PER;
    else if (start) per_q <= per_eff;
  end

  cc_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active), .per(per_q),
    .bit_end(bit_end), .first_half(first_half));

  cc_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_end(bit_end),
    .active(active), .slot(slot));

  cc_byte_latch u_bytes (
    .clk(clk), .rst_n(rst_n), .capture(start), .hold(active), .sel_odd(field_odd),
    .parity_gen(parity_gen), .odd_b0(odd_byte0), .odd_b1(odd_byte1),
    .even_b0(even_byte0), .even_b1(even_byte1), .word(word));

  assign didx = 4'(slot - SLOT_W'(DATA_SLOT0));

  always_comb begin
    data_bit = 1'b0;
    if (active) begin
      if (slot < SLOT_W'(NUM_RUNIN))             data_bit = first_half;
      else if (slot == SLOT_W'(DATA_SLOT0 - 1))  data_bit = 1'b1;
      else if (slot >= SLOT_W'(DATA_SLOT0))      data_bit = word[didx];
    end
  end

  assign data_valid = active;

  assert_blank_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> !data_bit);
  assert_period_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> per_q >= DIV_W'(2));
  assert_period_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |-> $stable(per_q));
endmodule

// File: tb/tb_cc_line_serializer.sv
module tb_cc_line_serializer;
  logic       clk = 0, rst_n = 0, line_start = 0, field_odd = 1, parity_gen = 0;
  logic [9:0] line_num = 0, odd_line = 21, even_line = 284;
  logic [7:0] bit_div = 0;
  logic [7:0] odd_byte0 = 0, odd_byte1 = 0, even_byte0 = 0, even_byte1 = 0;
  logic       data_bit, data_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cc_line_serializer dut (.*);

  function automatic logic [7:0] par(input logic [7:0] b, input logic g);
    return g ? {~^b[6:0], b[6:0]} : b;
  endfunction

  function automatic logic exp_bit(input int k, input int p, input logic [15:0] w);
    int s = k / p;
    int ph = k % p;
    if (s < 7) return ph < p / 2;   // R3
    if (s < 9) return 1'b0;          // R4
    if (s == 9) return 1'b1;         // R4
    return w[s - 10];                // R5
  endfunction

  function automatic string req_of(input int s);
    if (s < 7) return "R3";
    if (s < 10) return "R4";
    return "R5";
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // R2 R6 R10: one window; mutate inputs and re-pulse line_start at mut_at (R9)
  task automatic run_line(input logic fodd, input int mut_at);
    int p;
    logic [15:0] w;
    @(negedge clk);
    field_odd = fodd;
    line_num  = fodd ? odd_line : even_line;
    p = (bit_div < 2) ? 32 : int'(bit_div);                       // R8
    w = fodd ? {par(odd_byte1, parity_gen), par(odd_byte0, parity_gen)}     // R6 R7
             : {par(even_byte1, parity_gen), par(even_byte0, parity_gen)};
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    for (int k = 0; k < 26 * p; k++) begin
      chk(data_valid, 1'b1, "R10");
      chk(data_bit, exp_bit(k, p, w), req_of(k / p));
      if (k == mut_at) begin  // R9
        odd_byte0 = $urandom; odd_byte1 = $urandom;
        even_byte0 = $urandom; even_byte1 = $urandom;
        parity_gen = ~parity_gen; bit_div = 8'($urandom_range(2, 9));
        line_start = 1;
      end else line_start = 0;
      @(negedge clk);
    end
    line_start = 0;
    chk(data_valid, 1'b0, "R10");
    chk(data_bit, 1'b0, "R1");
  endtask

  task automatic no_start(input logic fodd, input logic [9:0] ln);
    @(negedge clk);
    field_odd = fodd; line_num = ln; line_start = 1;
    @(negedge clk);
    line_start = 0;
    for (int k = 0; k < 40; k++) begin
      chk(data_valid, 1'b0, "R2");
      chk(data_bit, 1'b0, "R2");
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(data_valid, 1'b0, "R1");
    chk(data_bit, 1'b0, "R1");

    // R8 default period via bit_div 0 and 1; R7 pass-through with odd/even data
    odd_byte0 = 8'h14; odd_byte1 = 8'hA7; bit_div = 0; parity_gen = 0;
    run_line(1'b1, -1);
    even_byte0 = 8'h80; even_byte1 = 8'h01; bit_div = 1; parity_gen = 1;
    run_line(1'b0, -1);
    // R3 odd and minimum periods
    bit_div = 3; run_line(1'b1, -1);
    bit_div = 2; run_line(1'b0, -1);
    // R2 mismatched line, and odd line number given on even field
    no_start(1'b1, odd_line + 10'd1);
    no_start(1'b0, odd_line);
    // R9 change everything mid-window, then the next window picks it up
    bit_div = 4; run_line(1'b1, 50);
    run_line(1'b1, -1);
    bit_div = 5; run_line(1'b0, 70);
    run_line(1'b0, -1);
    // random windows, both fields, both parity modes
    for (int i = 0; i < 24; i++) begin
      odd_byte0 = $urandom; odd_byte1 = $urandom;
      even_byte0 = $urandom; even_byte1 = $urandom;
      parity_gen = 1'($urandom); bit_div = 8'($urandom_range(0, 12));
      odd_line = 10'($urandom_range(10, 30)); even_line = 10'($urandom_range(270, 300));
      run_line(1'($urandom), -1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule